// File: doc/BRIEF.md
# Mixed-Pin GPIO Port Controller

This block is the register-mapped controller for one irregular I/O port. The port has three kinds of pin: six bidirectional pins, a set of input-only pins and twenty-four output-only pins. A host reaches it over a simple word bus with a select, a write flag, a byte address and data in both directions. Output levels and direction bits are never written as a whole word. Separate addresses set or clear individual bits, so one driver can change its own pins without a read-modify-write that could disturb another driver's pins.

The difficult part is the bit layout. The bidirectional pins drive from the high bits of the output word. Their sampled levels come back in two separate places in the input word. Their direction bits share a word with a 13-pin neighbouring port, and the block passes those neighbour bits out unchanged. Every pin input goes through a two-flop synchronizer before it reaches the input-state word. A read returns its data on the cycle after the strobe.

Top module: `mpio_port_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the output levels, the output enables, the neighbour direction bits, `bus_rdata` and `bus_rvalid` are all zero.
- R2: A write to byte offset 0x004 sets every output-word bit that is 1 in the write data. A write to 0x008 clears every output-word bit that is 1 in the write data. Bits written as 0 keep their value. The new value reaches the pins on the cycle after the write strobe.
- R3: Offsets 0x010 and 0x014 set and clear bits of the direction word in the same way. A direction bit of 1 makes its pin an output (enable high), and 0 makes it an input.
- R4: Output-only pin k (0 to 23) is driven from output-word bit k. Bidirectional pin n (0 to 5) is driven from output-word bit n+25.
- R5: The enable of bidirectional pin n comes from direction-word bit n+25. Direction-word bits 0 to 12 go out unchanged on `nbr_dir_o` for the neighbouring port.
- R6: The input-state word at offset 0x000 carries input-only pin k at bit k for k = 0..9, 15..23 and 25..28. Bidirectional pins 0 to 4 appear at bits 10 to 14, and bidirectional pin 5 appears at bit 24. Input-only lines 10 to 14 and 24 are not sampled.
- R7: A read strobe returns its data on `bus_rdata`, with `bus_rvalid` high, on the next cycle. A pin level present before clock edge E is absent from reads strobed at E and E+1. It appears in reads strobed at E+2 or later.
- R8: Reading 0x00C returns the stored output word, and reading 0x018 returns the stored direction word. Bits that map to no pin (output bits 24 and 31, direction bits 13 to 24 and 31) always read as 0.
- R9: Writes to offsets 0x000, 0x00C, 0x018 or any unmapped offset change no stored state. Reads of unmapped offsets return 0.
- R10: An output level written while its pin is an input is already present on the pin in the cycle the pin's enable rises. A direction write never changes an output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| bidir_in | input | 6 | Pad levels of the bidirectional pins |
| in_only_i | input | 29 | Pad levels of the input-only lines |
| bidir_out | output | 6 | Output levels of the bidirectional pins |
| bidir_oe | output | 6 | Output enables of the bidirectional pins |
| out_only_o | output | 24 | Levels of the output-only pins |
| nbr_dir_o | output | 13 | Direction bits of the neighbouring port |

## Verification
The hardest situation to reach from the ports is the exact timing edge of the synchronizer. The stimulus changes a bidirectional pin and an input-only line in the same cycle as a read strobe, then keeps strobing reads on the next two edges. It checks that the old value is seen twice before the new one appears. The scattered input layout is covered by random input words whose bits 10 to 14 and 24 are unrelated to the bidirectional levels, so any aliasing between the two pin classes shows up. The level-before-direction sequence is also run directly on single pins.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 8;
    localparam int BIDIR_N       = 6;
    localparam int BIDIR_OUT_LSB = 25;
    localparam int BIDIR_IN_LSB  = 10;
    localparam int BIDIR_IN_LAST = 24;
    localparam int OUTONLY_N     = 24;
    localparam int INONLY_N      = 29;
    localparam int NBR_DIR_N     = 13;

    typedef enum logic [ADDR_W-1:0] {
        OFF_IN_STATE  = 8'h00,
        OFF_OUT_SET   = 8'h04,
        OFF_OUT_CLR   = 8'h08,
        OFF_OUT_STATE = 8'h0C,
        OFF_DIR_SET   = 8'h10,
        OFF_DIR_CLR   = 8'h14,
        OFF_DIR_STATE = 8'h18
    } reg_off_e;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_IN   = 2'd1,
        RD_OUT  = 2'd2,
        RD_DIR  = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic    out_set;
        logic    out_clr;
        logic    dir_set;
        logic    dir_clr;
        rd_src_e rd_src;
    } access_t;

    function automatic access_t decode(input logic sel, input logic wr,
                                       input logic [ADDR_W-1:0] addr);
        access_t a;
        a = '{out_set: 1'b0, out_clr: 1'b0, dir_set: 1'b0, dir_clr: 1'b0,
              rd_src: RD_ZERO};
        if (sel && wr) begin
            a.out_set = (addr == OFF_OUT_SET);
            a.out_clr = (addr == OFF_OUT_CLR);
            a.dir_set = (addr == OFF_DIR_SET);
            a.dir_clr = (addr == OFF_DIR_CLR);
        end else if (sel) begin
            case (addr)
                OFF_IN_STATE:  a.rd_src = RD_IN;
                OFF_OUT_STATE: a.rd_src = RD_OUT;
                OFF_DIR_STATE: a.rd_src = RD_DIR;
                default:       a.rd_src = RD_ZERO;
            endcase
        end
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] out_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < OUTONLY_N; i++) m[i] = 1'b1;
        for (int i = 0; i < BIDIR_N; i++)   m[BIDIR_OUT_LSB+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] dir_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < NBR_DIR_N; i++) m[i] = 1'b1;
        for (int i = 0; i < BIDIR_N; i++)   m[BIDIR_OUT_LSB+i] = 1'b1;
        return m;
    endfunction

    function automatic int bidir_in_bit(input int n);
        return (n == BIDIR_N - 1) ? BIDIR_IN_LAST : BIDIR_IN_LSB + n;
    endfunction

    function automatic logic inonly_used(input int k);
        return !((k >= BIDIR_IN_LSB && k < BIDIR_IN_LSB + BIDIR_N - 1) ||
                 k == BIDIR_IN_LAST);
    endfunction

    function automatic logic [DATA_W-1:0] pack_inputs(
        input logic [BIDIR_N-1:0]  bi,
        input logic [INONLY_N-1:0] ii);
        logic [DATA_W-1:0] w = '0;
        for (int k = 0; k < INONLY_N; k++)
            if (inonly_used(k)) w[k] = ii[k];
        for (int n = 0; n < BIDIR_N; n++) w[bidir_in_bit(n)] = bi[n];
        return w;
    endfunction

endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mpio_w1sc_reg.sv
module mpio_w1sc_reg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (set_en) nxt = nxt | bits;
        if (clr_en) nxt = nxt & ~bits;
        nxt = nxt & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R2 / R3: written ones take effect next cycle, zeros preserve state
    p_set_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ((q & $past(bits & MASK)) == $past(bits & MASK)));
    p_clr_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((q & $past(bits)) == '0));
    p_zero_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits))));
endmodule

// File: rtl/mpio_port_ctrl.sv
module mpio_port_ctrl
    import mpio_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_rvalid,
    input  logic [BIDIR_N-1:0]   bidir_in,
    input  logic [INONLY_N-1:0]  in_only_i,
    output logic [BIDIR_N-1:0]   bidir_out,
    output logic [BIDIR_N-1:0]   bidir_oe,
    output logic [OUTONLY_N-1:0] out_only_o,
    output logic [NBR_DIR_N-1:0] nbr_dir_o
);
    localparam logic [DW-1:0] OUT_MASK = out_mask();
    localparam logic [DW-1:0] DIR_MASK = dir_mask();

    access_t           acc;
    logic [DW-1:0]     out_word, dir_word, in_word;
    logic [BIDIR_N-1:0]  bi_sync;
    logic [INONLY_N-1:0] ii_sync;

    assign acc = decode(bus_sel, bus_wr, bus_addr);

    mpio_sync #(.W(BIDIR_N)) u_sync_bi (
        .clk(clk), .rst(rst), .d(bidir_in), .q(bi_sync));
    mpio_sync #(.W(INONLY_N)) u_sync_ii (
        .clk(clk), .rst(rst), .d(in_only_i), .q(ii_sync));

    assign in_word = pack_inputs(bi_sync, ii_sync);

    mpio_w1sc_reg #(.W(DW), .MASK(OUT_MASK)) u_out_reg (
        .clk(clk), .rst(rst), .set_en(acc.out_set), .clr_en(acc.out_clr),
        .bits(bus_wdata), .q(out_word));
    mpio_w1sc_reg #(.W(DW), .MASK(DIR_MASK)) u_dir_reg (
        .clk(clk), .rst(rst), .set_en(acc.dir_set), .clr_en(acc.dir_clr),
        .bits(bus_wdata), .q(dir_word));

    assign out_only_o = out_word[OUTONLY_N-1:0];
    assign nbr_dir_o  = dir_word[NBR_DIR_N-1:0];

    for (genvar n = 0; n < BIDIR_N; n++) begin : g_bidir
        assign bidir_out[n] = out_word[BIDIR_OUT_LSB+n];
        assign bidir_oe[n]  = dir_word[BIDIR_OUT_LSB+n];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            case (acc.rd_src)
                RD_IN:   bus_rdata <= in_word;
                RD_OUT:  bus_rdata <= out_word;
                RD_DIR:  bus_rdata <= dir_word;
                default: bus_rdata <= '0;
            endcase
        end
    end

    // R1: everything is quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (bidir_oe == '0 && out_only_o == '0 && bidir_out == '0 &&
                 nbr_dir_o == '0 && !bus_rvalid));
    // R7: a read strobe is answered on the next cycle
    p_read_lat_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    // R9: writes to read-only or unmapped offsets leave the pins alone
    p_ro_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr != OFF_OUT_SET && bus_addr != OFF_OUT_CLR &&
         bus_addr != OFF_DIR_SET && bus_addr != OFF_DIR_CLR)
        |=> ($stable(out_only_o) && $stable(bidir_out) && $stable(bidir_oe) &&
             $stable(nbr_dir_o)));
    // R10: enabling a pin never changes its level in that cycle
    p_oe_level_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(bidir_oe[0]) |-> $stable(bidir_out[0]));
    p_oe_level5_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(bidir_oe[BIDIR_N-1]) |-> $stable(bidir_out[BIDIR_N-1]));
endmodule

// File: tb/mpio_port_ctrl_tb.sv
module mpio_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [5:0]  bidir_in = '0;
    logic [28:0] in_only_i = '0;
    logic [5:0]  bidir_out, bidir_oe;
    logic [23:0] out_only_o;
    logic [12:0] nbr_dir_o;

    localparam logic [31:0] OUTM = 32'h7EFF_FFFF;
    localparam logic [31:0] DIRM = 32'h7E00_1FFF;
    localparam logic [31:0] INM  = 32'h1EFF_83FF;

    int n_vec = 0, n_err = 0;
    bit done = 0;
    logic [31:0] out_m = '0, dir_m = '0;

    always #2 clk = ~clk;

    mpio_port_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bidir_in(bidir_in), .in_only_i(in_only_i),
        .bidir_out(bidir_out), .bidir_oe(bidir_oe), .out_only_o(out_only_o),
        .nbr_dir_o(nbr_dir_o));

    function automatic logic [31:0] exp_in(input logic [5:0] bi, input logic [28:0] ii);
        return ({3'b0, ii} & INM) | ({27'b0, bi[4:0]} << 10) | ({31'b0, bi[5]} << 24);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return exp_in(bidir_in, in_only_i);
            8'h0C:   return out_m;
            8'h18:   return dir_m;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req);
        chk({req, " out_only"}, {8'h0, out_only_o}, {8'h0, out_m[23:0]});
        chk({req, " bidir_out R4"}, {26'h0, bidir_out}, {26'h0, out_m[30:25]});
        chk({req, " bidir_oe R5"}, {26'h0, bidir_oe}, {26'h0, dir_m[30:25]});
        chk({req, " nbr_dir R5"}, {19'h0, nbr_dir_o}, {19'h0, dir_m[12:0]});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            8'h04: out_m = (out_m | d) & OUTM;
            8'h08: out_m = out_m & ~d;
            8'h10: dir_m = (dir_m | d) & DIRM;
            8'h14: dir_m = dir_m & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        e = exp_read(a);
        @(negedge clk);
        bus_sel = 1'b0;
        chk({req, " rvalid R7"}, {31'h0, bus_rvalid}, 32'h1);
        chk(req, bus_rdata, e);
    endtask

    task automatic set_inputs(input logic [5:0] bi, input logic [28:0] ii);
        @(negedge clk);
        bidir_in = bi; in_only_i = ii;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [5:0]  old_bi;
        logic [28:0] old_ii;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 reset out", {8'h0, out_only_o}, 32'h0);
        chk("R1 reset oe", {26'h0, bidir_oe}, 32'h0);
        chk("R1 reset rdata", bus_rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk_pins("R1 after reset");
        chk("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);

        // R2 / R8: set everything, unused bits read back zero
        wr(8'h04, 32'hFFFF_FFFF); chk_pins("R2 set all");
        rd(8'h0C, "R8 out readback");
        wr(8'h08, 32'h00F0_000F); chk_pins("R2 partial clear");
        rd(8'h0C, "R8 out readback");
        // R3 / R8
        wr(8'h10, 32'hFFFF_FFFF); chk_pins("R3 dir set all");
        rd(8'h18, "R8 dir readback");
        wr(8'h14, 32'h4200_1001); chk_pins("R3 dir clear");
        rd(8'h18, "R8 dir readback");

        // R9: writes to read-only and unmapped offsets
        wr(8'h00, 32'h0); wr(8'h0C, 32'h0); wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0); wr(8'hFC, 32'hFFFF_FFFF);
        chk_pins("R9 ignored writes");
        rd(8'h0C, "R9 out after ignored writes");
        rd(8'h18, "R9 dir after ignored writes");
        rd(8'h1C, "R9 unmapped read");
        rd(8'h40, "R9 unmapped read");
        rd(8'h04, "R9 set-offset read");

        // R10: level first, then direction, on bidir pin 3 and pin 5
        wr(8'h08, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h04, 32'h1000_0000); chk_pins("R10 level while input");
        wr(8'h10, 32'h1000_0000); chk_pins("R10 dir after level");
        wr(8'h04, 32'h4000_0000); wr(8'h10, 32'h4000_0000);
        chk_pins("R10 pin5");

        // R6 directed: bidir levels land at 10..14 and 24
        set_inputs(6'b10_0101, 29'h0);
        rd(8'h00, "R6 bidir only");
        set_inputs(6'h0, 29'h1FFF_FFFF);
        rd(8'h00, "R6 inonly only");
        set_inputs(6'h3F, 29'h0);
        rd(8'h00, "R6 all bidir");

        // R7: synchronizer edge timing
        old_bi = bidir_in; old_ii = in_only_i;
        @(negedge clk);
        bidir_in = 6'h00; in_only_i = 29'h0000_0201;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        @(negedge clk);
        chk("R7 strobe at E", bus_rdata, exp_in(old_bi, old_ii));
        @(negedge clk);
        chk("R7 strobe at E+1", bus_rdata, exp_in(old_bi, old_ii));
        @(negedge clk);
        chk("R7 strobe at E+2", bus_rdata, exp_in(bidir_in, in_only_i));
        bus_sel = 1'b0;

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 7);
            d  = $urandom();
            case (op)
                0: begin wr(8'h04, d); chk_pins("R2 rand set"); end
                1: begin wr(8'h08, d); chk_pins("R2 rand clr"); end
                2: begin wr(8'h10, d); chk_pins("R3 rand dir set"); end
                3: begin wr(8'h14, d); chk_pins("R3 rand dir clr"); end
                4: begin
                    wr(8'h00 + 8'($urandom_range(0, 15) * 4) | 8'h40, d);
                    chk_pins("R9 rand ignored");
                end
                5: set_inputs(6'($urandom()), 29'($urandom()));
                default: begin
                    logic [7:0] a;
                    a = 8'($urandom_range(0, 9) * 4);
                    rd(a, "R6 R8 R9 rand read");
                end
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule